// File: doc/BRIEF.md
# Dual-Speed Peripheral Clock Controller

This block paces an 8-bit microcontroller core and six of its peripherals. It owns one 8-bit control register on the special-function-register (SFR) bus. From a shared free-running modulo-12 phase counter it produces one-cycle clock-enable strobes. One strobe paces the CPU machine cycle. Six more pace the watchdog, the counter array, the UART and timers 0, 1 and 2.

Each strobe fires either once every 12 oscillator clocks (slow) or once every 6 (fast). A global speed bit sets the CPU rate and decides whether the per-peripheral speed bits are honoured. After reset the global bit takes the value of a configuration input. Any rate change is held back until the next 12-clock boundary, so no strobe interval is ever shortened or stretched.

Top module: `pclk_rate_ctl`

## Requirements
- R1: While rst_ni is low and afterwards until the first write, register bits 7..1 read 0 and bit 0 reads the value of boot_fast_i.
- R2: A write (sfr_we_i high at a rising clock edge) to address 0x8F loads bits 6..0 from sfr_wdata_i. A write to any other address leaves the register unchanged.
- R3: Bit 7 of the register cannot be written and always reads 0.
- R4: sfr_rdata_o shows the register in the same cycle when sfr_addr_i equals 0x8F, and shows 0x00 for any other address.
- R5: The phase counter counts 0..11 and wraps. Position 0 is the 12-clock boundary, and every strobe is high for exactly one clock at a time.
- R6: With the applied global bit (register bit 0) at 0, cpu_stb_o and every per_stb_o bit fire only at phase 0, once every 12 clocks.
- R7: With the applied global bit at 1, cpu_stb_o fires at phases 0 and 6, once every 6 clocks.
- R8: With the applied global bit at 1, per_stb_o[i] is governed by register bit i+1 (bit 6 watchdog = [5], bit 5 counter array = [4], bit 4 UART = [3], bit 3 timer 2 = [2], bit 2 timer 1 = [1], bit 1 timer 0 = [0]). A 0 fires the strobe at phases 0 and 6; a 1 fires it at phase 0 only.
- R9: Register contents are applied to the strobes only at the 11-to-0 phase transition. A write sampled in the phase-11 cycle already governs the strobes from the phase-0 cycle that follows.
- R10: Whenever any per_stb_o bit is high, cpu_stb_o is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_fast_i | input | 1 | Reset value of the global speed bit |
| sfr_we_i | input | 1 | SFR write strobe |
| sfr_addr_i | input | 8 | SFR address, shared by read and write |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data (combinational) |
| cpu_stb_o | output | 1 | CPU machine-cycle enable |
| per_stb_o | output | 6 | Peripheral enables: [5] watchdog, [4] counter array, [3] UART, [2] timer 2, [1] timer 1, [0] timer 0 |

## Verification
A register write and the 12-clock apply point can fall on the same edge, and the write must then win. The bench provokes this by waiting for phase 11 and writing a new rate there. It expects the new rate at the very next phase-6 strobe. A second directed case writes in mid-period and expects the old rate to persist until the wrap. Random writes with stray addresses and bit-7 data run against a cycle model in the bench, so these collisions also arise at random phases.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int NUM_PER = 6;
  localparam int CFG_W   = NUM_PER + 1;

  // bit 0 global fast, bits NUM_PER..1 per-peripheral slow selects
  typedef struct packed {
    logic [NUM_PER-1:0] per_slow;
    logic               glob_fast;
  } rate_cfg_t;
endpackage

// File: rtl/pcc_phase_cnt.sv
module pcc_phase_cnt #(
  parameter int PERIOD = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic at_full_o,
  output logic at_half_o,
  output logic at_last_o
);
  localparam int CW   = $clog2(PERIOD);
  localparam int HALF = PERIOD / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (cnt_q == CW'(PERIOD - 1))    cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  assign at_full_o = (cnt_q == '0);
  assign at_half_o = (cnt_q == CW'(HALF));
  assign at_last_o = (cnt_q == CW'(PERIOD - 1));

  // R5
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(PERIOD - 1)) |=> (cnt_q == '0));
  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(PERIOD));
endmodule

// File: rtl/pcc_ctl_reg.sv
module pcc_ctl_reg
  import pcc_pkg::*;
#(
  parameter int          AW   = 8,
  parameter int          DW   = 8,
  parameter logic [AW-1:0] ADDR = 8'h8F
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          boot_fast_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output rate_cfg_t     cfg_q_o,
  output rate_cfg_t     cfg_d_o
);
  localparam int PAD = DW - CFG_W;

  rate_cfg_t cfg_q, cfg_d;
  logic      hit;

  assign hit = (addr_i == ADDR);

  always_comb begin
    cfg_d = cfg_q;
    if (we_i && hit) cfg_d = rate_cfg_t'(wdata_i[CFG_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.per_slow  <= '0;
      cfg_q.glob_fast <= boot_fast_i;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  // upper bits are reserved: never stored, read as zero
  assign rdata_o = hit ? {{PAD{1'b0}}, cfg_q} : '0;
  assign cfg_q_o = cfg_q;
  assign cfg_d_o = cfg_d;

  // R2
  foreign_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && hit) |=> $stable(cfg_q));
endmodule

// File: rtl/pcc_strobe_gen.sv
module pcc_strobe_gen
  import pcc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               boot_fast_i,
  input  rate_cfg_t          cfg_d_i,
  input  logic               at_full_i,
  input  logic               at_half_i,
  input  logic               at_last_i,
  output logic               cpu_stb_o,
  output logic [NUM_PER-1:0] per_stb_o
);
  rate_cfg_t app_q;

  // next-state value so a write on the wrap edge applies at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      app_q.per_slow  <= '0;
      app_q.glob_fast <= boot_fast_i;
    end else if (at_last_i) begin
      app_q <= cfg_d_i;
    end
  end

  assign cpu_stb_o = at_full_i | (app_q.glob_fast & at_half_i);

  for (genvar i = 0; i < NUM_PER; i++) begin : g_per
    assign per_stb_o[i] = at_full_i |
                          (app_q.glob_fast & ~app_q.per_slow[i] & at_half_i);
  end

  // R9
  apply_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_last_i |=> $stable(app_q));
  // R6
  slow_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!app_q.glob_fast && !at_full_i) |-> (!cpu_stb_o && per_stb_o == '0));
endmodule

// File: rtl/pclk_rate_ctl.sv
module pclk_rate_ctl
  import pcc_pkg::*;
#(
  parameter int            AW     = 8,
  parameter int            DW     = 8,
  parameter logic [AW-1:0] ADDR   = 8'h8F,
  parameter int            PERIOD = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               boot_fast_i,
  input  logic               sfr_we_i,
  input  logic [AW-1:0]      sfr_addr_i,
  input  logic [DW-1:0]      sfr_wdata_i,
  output logic [DW-1:0]      sfr_rdata_o,
  output logic               cpu_stb_o,
  output logic [NUM_PER-1:0] per_stb_o
);
  rate_cfg_t cfg_q, cfg_d;
  logic      at_full, at_half, at_last;

  pcc_phase_cnt #(.PERIOD(PERIOD)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .at_full_o(at_full),
    .at_half_o(at_half),
    .at_last_o(at_last)
  );

  pcc_ctl_reg #(.AW(AW), .DW(DW), .ADDR(ADDR)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boot_fast_i(boot_fast_i),
    .we_i       (sfr_we_i),
    .addr_i     (sfr_addr_i),
    .wdata_i    (sfr_wdata_i),
    .rdata_o    (sfr_rdata_o),
    .cfg_q_o    (cfg_q),
    .cfg_d_o    (cfg_d)
  );

  pcc_strobe_gen u_stb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boot_fast_i(boot_fast_i),
    .cfg_d_i    (cfg_d),
    .at_full_i  (at_full),
    .at_half_i  (at_half),
    .at_last_i  (at_last),
    .cpu_stb_o  (cpu_stb_o),
    .per_stb_o  (per_stb_o)
  );

  // R10
  per_in_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_stb_o != '0) |-> cpu_stb_o);
  // R5
  stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_stb_o |=> !cpu_stb_o);
  // R3
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sfr_rdata_o[DW-1]);
endmodule

// File: tb/pclk_rate_ctl_tb.sv
`timescale 1ns/1ps
module pclk_rate_ctl_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       boot_fast = 0;
  logic       we = 0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       cpu_stb;
  logic [5:0] per_stb;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pclk_rate_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .boot_fast_i(boot_fast),
    .sfr_we_i(we), .sfr_addr_i(addr), .sfr_wdata_i(wdata),
    .sfr_rdata_o(rdata), .cpu_stb_o(cpu_stb), .per_stb_o(per_stb)
  );

  // reference model built from the requirements
  int       m_cnt;
  logic [6:0] m_reg, m_app;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0;
      m_reg <= {6'b0, boot_fast};
      m_app <= {6'b0, boot_fast};
    end else begin
      logic [6:0] nreg;
      nreg = (we && addr == 8'h8F) ? wdata[6:0] : m_reg;
      m_reg <= nreg;
      if (m_cnt == 11) m_app <= nreg;
      m_cnt <= (m_cnt == 11) ? 0 : m_cnt + 1;
    end
  end

  function automatic logic exp_cpu();
    return (m_cnt == 0) || (m_app[0] && m_cnt == 6);
  endfunction

  function automatic logic [5:0] exp_per();
    logic [5:0] r;
    for (int i = 0; i < 6; i++)
      r[i] = (m_cnt == 0) || (m_app[0] && !m_app[i+1] && m_cnt == 6);
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    return (a == 8'h8F) ? {1'b0, m_reg} : 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: compare strobes, drive next inputs, compare read data
  task automatic tick(logic w, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    chk(m_app[0] ? "R7" : "R6", cpu_stb, exp_cpu());
    chk(m_app[0] ? "R8" : "R6", per_stb, exp_per());
    if (per_stb != 0) chk("R10", cpu_stb, 1);
    we = w; addr = a; wdata = d;
    #1;
    chk("R4", rdata, exp_rd(a));
  endtask

  task automatic idle_until(int k);
    int guard = 0;
    do begin
      tick(0, 8'h8F, 8'h00);
      guard++;
    end while (m_cnt != k && guard < 30);
  endtask

  task automatic do_reset(logic b);
    @(negedge clk);
    rst_n = 0; boot_fast = b; we = 0; addr = 8'h8F;
    #1;
    chk("R1", rdata, {7'b0, b});
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", rdata, {7'b0, b});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    // R1 reset with boot slow, then R5/R6 gap between CPU strobes
    do_reset(1'b0);
    begin
      int last = -1, gap = 0, width_ok = 1;
      logic prev = 0;
      for (int c = 0; c < 40; c++) begin
        tick(0, 8'h8F, 8'h00);
        if (cpu_stb && prev) width_ok = 0;
        if (cpu_stb) begin
          if (last >= 0) gap = c - last;
          last = c;
        end
        prev = cpu_stb;
      end
      chk("R5", gap, 12);
      chk("R5", width_ok, 1);
    end

    // R1 reset with boot fast
    do_reset(1'b1);
    idle_until(6);
    chk("R7", cpu_stb, 1);
    chk("R8", per_stb, 6'h3F);

    // R3 bit 7 write ignored
    tick(1, 8'h8F, 8'hFF);
    tick(0, 8'h8F, 8'h00);
    chk("R3", rdata, 8'h7F);
    // R2 foreign address write ignored
    tick(1, 8'h8E, 8'h00);
    tick(0, 8'h8F, 8'h00);
    chk("R2", rdata, 8'h7F);
    // R2 write of mixed bits
    tick(1, 8'h8F, 8'h2B);
    tick(0, 8'h8F, 8'h00);
    chk("R2", rdata, 8'h2B);

    // R8 mapping: 0x2B -> slow bits 5,3,1 -> per[4],[2],[0] slow
    idle_until(0);
    idle_until(6);
    chk("R8", per_stb, 6'b101010);

    // R9 mid-period write keeps old rate until wrap
    tick(1, 8'h8F, 8'h01);
    idle_until(0);
    idle_until(2);
    we = 1; addr = 8'h8F; wdata = 8'h7F;
    idle_until(6);
    chk("R9", per_stb, 6'h3F);
    idle_until(6);
    chk("R9", per_stb, 6'h00);

    // R9 collision: write in phase-11 cycle applies at the wrap
    idle_until(11);
    we = 1; addr = 8'h8F; wdata = 8'h01;
    idle_until(6);
    chk("R9", per_stb, 6'h3F);
    // R6 global off disables per bits
    idle_until(11);
    we = 1; addr = 8'h8F; wdata = 8'h00;
    idle_until(6);
    chk("R6", {cpu_stb, per_stb}, 7'h00);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic w;
      logic [7:0] a;
      w = ($urandom % 6) == 0;
      a = ($urandom % 4 != 0) ? 8'h8F : 8'($urandom);
      tick(w, a, 8'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule